// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This combinational block connects a 32-bit load/store datapath to a data memory that is one word wide. Each access supplies an opcode, a base register value, a 16-bit signed displacement and store data. The block forms the effective byte address and passes the word part to the memory. For stores it drives per-lane write enables and a write word whose bytes sit on the lanes the memory expects. For loads it returns a 32-bit register value. A byte load is sign-extended from the addressed lane.

A mode input selects the byte order. In little-endian mode the lowest address holds the least significant byte of a word. In big-endian mode it holds the most significant byte. Word stores and word loads pass the register word through unchanged, so the byte order only decides which lane a byte access uses. A word access whose two low address bits are not zero is flagged as misaligned and has no effect on memory.

Top module: `lsu_byte_lane`

## Requirements
- R1: `word_addr` equals bits [31:2] of `base_val` plus `offset` sign-extended to 32 bits. The sum wraps modulo 2^32.
- R2: Lane k is bits [8k+7:8k] of the memory word. With `ea` the effective address, the addressed lane is `ea[1:0]` when `big_end`=0 and 3−`ea[1:0]` when `big_end`=1.
- R3: Opcode 0x20 (byte load) sets `load_val` to the addressed lane of `mem_rdata`, sign-extended from its bit 7. `byte_wen` is 0.
- R4: Opcode 0x28 (byte store) asserts exactly the one `byte_wen` bit of the addressed lane. `mem_wdata` carries `st_data[7:0]` on that lane and zero on the other lanes.
- R5: When `ea[1:0]`=0, opcode 0x2b (word store) sets `byte_wen`=4'b1111 and `mem_wdata`=`st_data`, and opcode 0x23 (word load) sets `load_val`=`mem_rdata`.
- R6: When `ea[1:0]`≠0, opcodes 0x23 and 0x2b set `misaligned`=1, `byte_wen`=0 and `load_val`=0. Byte accesses never set `misaligned`.
- R7: Any other opcode gives `byte_wen`=0, `misaligned`=0 and `load_val`=0. `load_val` is 0 for stores, and `mem_wdata` is 0 for all opcodes other than stores.
- R8: After a word store of 0x12345678 at address A, a byte load from A returns 0x78 in little-endian mode and 0x12 in big-endian mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Access opcode: 0x20, 0x23, 0x28 or 0x2b |
| big_end | input | 1 | Byte-order mode: 1 selects big-endian |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed displacement |
| st_data | input | 32 | Register value to store |
| mem_rdata | input | 32 | Word read from memory |
| word_addr | output | 30 | Word address sent to memory |
| byte_wen | output | 4 | Write enable for each byte lane |
| mem_wdata | output | 32 | Write word with bytes placed on their lanes |
| load_val | output | 32 | Load result for the register file |
| misaligned | output | 1 | Word access at an address that is not a multiple of four |

## Verification
Some properties are checked by the assertions on every evaluation. A byte store enables exactly one lane, and that lane carries the low store byte. A misaligned word access writes nothing. An aligned word store enables every lane. A byte load result has its upper 24 bits equal to its bit 7. Other behaviour needs the bench's memory model and scenarios. These cover the address sum with negative and wrapping displacements, the lane choice under each byte order, and the round trip of a stored word read back byte by byte. The bench also checks that untouched memory bytes keep their values across byte stores.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam logic [5:0] OP_LDB = 6'h20;
  localparam logic [5:0] OP_LDW = 6'h23;
  localparam logic [5:0] OP_STB = 6'h28;
  localparam logic [5:0] OP_STW = 6'h2b;

  typedef enum logic [1:0] {
    SZ_NONE = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  typedef struct packed {
    logic      rd;
    logic      wr;
    acc_size_e size;
  } acc_kind_t;

  function automatic acc_kind_t decode_access(input logic [5:0] op);
    acc_kind_t k;
    k = '{rd: 1'b0, wr: 1'b0, size: SZ_NONE};
    case (op)
      OP_LDB: k = '{rd: 1'b1, wr: 1'b0, size: SZ_BYTE};
      OP_LDW: k = '{rd: 1'b1, wr: 1'b0, size: SZ_WORD};
      OP_STB: k = '{rd: 1'b0, wr: 1'b1, size: SZ_BYTE};
      OP_STW: k = '{rd: 1'b0, wr: 1'b1, size: SZ_WORD};
      default: k = '{rd: 1'b0, wr: 1'b0, size: SZ_NONE};
    endcase
    return k;
  endfunction

endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int SEL_W  = 2
) (
  input  logic [ADDR_W-1:0]       base_val,
  input  logic [OFF_W-1:0]        offset,
  input  logic                    big_end,
  input  lsu_align_pkg::acc_kind_t kind,
  output logic [ADDR_W-SEL_W-1:0] word_addr,
  output logic [SEL_W-1:0]        lane,
  output logic                    misaligned
);
  import lsu_align_pkg::*;

  localparam int EXT_W = ADDR_W - OFF_W;

  function automatic logic [ADDR_W-1:0] eff_sum(input logic [ADDR_W-1:0] b,
                                                input logic [OFF_W-1:0] o);
    return b + {{EXT_W{o[OFF_W-1]}}, o};
  endfunction

  function automatic logic [SEL_W-1:0] lane_map(input logic [SEL_W-1:0] low,
                                                input logic be);
    return be ? ~low : low;
  endfunction

  logic [ADDR_W-1:0] ea;
  logic [SEL_W-1:0]  low_bits;

  assign ea         = eff_sum(base_val, offset);
  assign low_bits   = ea[SEL_W-1:0];
  assign word_addr  = ea[ADDR_W-1:SEL_W];
  assign lane       = lane_map(low_bits, big_end);
  assign misaligned = (kind.size == SZ_WORD) && (low_bits != '0);

endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input  lsu_align_pkg::acc_kind_t kind,
  input  logic [SEL_W-1:0]         lane,
  input  logic                     misaligned,
  input  logic [DATA_W-1:0]        st_data,
  output logic [DATA_W/8-1:0]      byte_wen,
  output logic [DATA_W-1:0]        mem_wdata
);
  import lsu_align_pkg::*;

  localparam int LANES = DATA_W / 8;

  logic byte_st;
  logic word_st;
  logic [LANES-1:0] hit;

  assign byte_st = kind.wr && (kind.size == SZ_BYTE);
  assign word_st = kind.wr && (kind.size == SZ_WORD) && !misaligned;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign hit[k]           = (lane == SEL_W'(k));
    assign byte_wen[k]      = (byte_st && hit[k]) || word_st;
    assign mem_wdata[8*k+:8] = word_st              ? st_data[8*k+:8] :
                               (byte_st && hit[k])  ? st_data[7:0]    : 8'h00;
  end

  always_comb begin
    if (byte_st) begin
      assert_byte_onehot_R4: assert ($countones(byte_wen) == 1);
    end
  end

  always_comb begin
    if (byte_st) begin
      for (int j = 0; j < LANES; j++) begin
        if (byte_wen[j]) begin
          assert_byte_on_lane_R4: assert (mem_wdata[8*j+:8] == st_data[7:0]);
        end
      end
    end
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract #(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 2
) (
  input  lsu_align_pkg::acc_kind_t kind,
  input  logic [SEL_W-1:0]         lane,
  input  logic                     misaligned,
  input  logic [DATA_W-1:0]        mem_rdata,
  output logic [DATA_W-1:0]        load_val
);
  import lsu_align_pkg::*;

  localparam int LANES = DATA_W / 8;

  function automatic logic [DATA_W-1:0] sext8(input logic [7:0] b);
    return {{(DATA_W-8){b[7]}}, b};
  endfunction

  logic [7:0] lane_byte [LANES];
  logic [7:0] picked;

  for (genvar k = 0; k < LANES; k++) begin : g_split
    assign lane_byte[k] = mem_rdata[8*k+:8];
  end

  assign picked = lane_byte[lane];

  always_comb begin
    load_val = '0;
    if (kind.rd && !misaligned) begin
      if (kind.size == SZ_BYTE) load_val = sext8(picked);
      else if (kind.size == SZ_WORD) load_val = mem_rdata;
    end
  end

  always_comb begin
    if (kind.rd && kind.size == SZ_BYTE) begin
      assert_sign_fill_R3: assert (load_val[DATA_W-1:8] == {(DATA_W-8){load_val[7]}});
    end
  end

endmodule

// File: rtl/lsu_byte_lane.sv
module lsu_byte_lane #(
  parameter int DATA_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [5:0]          op_code,
  input  logic                big_end,
  input  logic [DATA_W-1:0]   base_val,
  input  logic [OFF_W-1:0]    offset,
  input  logic [DATA_W-1:0]   st_data,
  input  logic [DATA_W-1:0]   mem_rdata,
  output logic [DATA_W-3:0]   word_addr,
  output logic [DATA_W/8-1:0] byte_wen,
  output logic [DATA_W-1:0]   mem_wdata,
  output logic [DATA_W-1:0]   load_val,
  output logic                misaligned
);
  import lsu_align_pkg::*;

  localparam int LANES = DATA_W / 8;
  localparam int SEL_W = $clog2(LANES);

  acc_kind_t        kind;
  logic [SEL_W-1:0] lane;
  logic             mis_w;

  assign kind       = decode_access(op_code);
  assign misaligned = mis_w;

  lsu_addr_gen #(.ADDR_W(DATA_W), .OFF_W(OFF_W), .SEL_W(SEL_W)) u_addr (
    .base_val  (base_val),
    .offset    (offset),
    .big_end   (big_end),
    .kind      (kind),
    .word_addr (word_addr),
    .lane      (lane),
    .misaligned(mis_w)
  );

  lsu_store_lane #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_store (
    .kind      (kind),
    .lane      (lane),
    .misaligned(mis_w),
    .st_data   (st_data),
    .byte_wen  (byte_wen),
    .mem_wdata (mem_wdata)
  );

  lsu_load_extract #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_load (
    .kind      (kind),
    .lane      (lane),
    .misaligned(mis_w),
    .mem_rdata (mem_rdata),
    .load_val  (load_val)
  );

  always_comb begin
    if (mis_w) begin
      assert_misaligned_no_write_R6: assert (byte_wen == '0 && load_val == '0);
    end
  end

  always_comb begin
    if (kind.wr && kind.size == SZ_WORD && !mis_w) begin
      assert_word_all_lanes_R5: assert (byte_wen == {LANES{1'b1}});
    end
  end

  always_comb begin
    if (!kind.wr) begin
      assert_no_write_when_not_store_R7: assert (byte_wen == '0);
    end
  end

endmodule

// File: tb/lsu_byte_lane_bench.sv
module lsu_byte_lane_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  op_code = 6'h0;
  logic        big_end = 1'b0;
  logic [31:0] base_val = 32'h0;
  logic [15:0] offset = 16'h0;
  logic [31:0] st_data = 32'h0;
  logic [31:0] mem_rdata;
  logic [29:0] word_addr;
  logic [3:0]  byte_wen;
  logic [31:0] mem_wdata;
  logic [31:0] load_val;
  logic        misaligned;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  logic [7:0] bytes_mem [256];

  always #10 clk = ~clk;

  lsu_byte_lane u_lsu_byte_lane (
    .op_code(op_code), .big_end(big_end), .base_val(base_val), .offset(offset),
    .st_data(st_data), .mem_rdata(mem_rdata), .word_addr(word_addr),
    .byte_wen(byte_wen), .mem_wdata(mem_wdata), .load_val(load_val),
    .misaligned(misaligned)
  );

  always_comb begin
    mem_rdata = '0;
    for (int k = 0; k < 4; k++)
      mem_rdata[8*k+:8] = bytes_mem[{word_addr[5:0], 2'(k)}];
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(input string req, input logic [5:0] op, input logic be,
                        input logic [31:0] b, input logic [15:0] o, input logic [31:0] d);
    logic [31:0] ea;
    int lane;
    bit is_word, aligned;
    logic [3:0]  e_wen;
    logic [31:0] e_wd, e_ld, rd;
    @(negedge clk);
    op_code = op; big_end = be; base_val = b; offset = o; st_data = d;
    #3;
    ea = b + 32'(signed'(o));
    lane = be ? 3 - int'(ea % 4) : int'(ea % 4);
    is_word = (op == 6'h23) || (op == 6'h2b);
    aligned = (ea % 4) == 0;
    rd = 0;
    for (int k = 0; k < 4; k++) rd = rd | (32'(bytes_mem[((ea / 4) % 64) * 4 + k]) << (8 * k));
    e_wen = 0; e_wd = 0; e_ld = 0;
    if (op == 6'h28) begin
      e_wen = 4'(1 << lane);
      e_wd = 32'(d & 32'hff) << (8 * lane);
    end else if (op == 6'h2b && aligned) begin
      e_wen = 4'hf; e_wd = d;
    end else if (op == 6'h23 && aligned) begin
      e_ld = rd;
    end else if (op == 6'h20) begin
      e_ld = (rd >> (8 * lane)) & 32'hff;
      if (e_ld >= 32'h80) e_ld = e_ld - 32'h100;
    end
    check("R1", "word_addr", {2'b00, word_addr}, ea / 4);
    check(req, "byte_wen", {28'h0, byte_wen}, {28'h0, e_wen});
    check(req, "mem_wdata", mem_wdata, e_wd);
    check(req, "load_val", load_val, e_ld);
    check(req, "misaligned", {31'h0, misaligned}, {31'h0, is_word && !aligned});
    @(posedge clk);
    #1;
    for (int k = 0; k < 4; k++)
      if (e_wen[k]) bytes_mem[((ea / 4) % 64) * 4 + k] = e_wd[8*k+:8];
  endtask

  initial begin
    for (int i = 0; i < 256; i++) bytes_mem[i] = 8'(i * 37 + 5);
    repeat (2) access("R7", 6'h00, 1'b0, 32'h0, 16'h0, 32'h0);
    rst = 1'b0;
    // R8 little-endian round trip
    access("R5", 6'h2b, 1'b0, 32'h40, 16'h0, 32'h12345678);
    access("R8", 6'h20, 1'b0, 32'h40, 16'h0, 32'h0);
    access("R8", 6'h20, 1'b0, 32'h40, 16'h3, 32'h0);
    // R8 big-endian round trip
    access("R5", 6'h2b, 1'b1, 32'h50, 16'h0, 32'h12345678);
    access("R8", 6'h20, 1'b1, 32'h50, 16'h0, 32'h0);
    access("R8", 6'h20, 1'b1, 32'h50, 16'h3, 32'h0);
    // R3 sign extension of negative bytes, each lane in both orders
    access("R5", 6'h2b, 1'b0, 32'h60, 16'h0, 32'h80ff7f01);
    for (int k = 0; k < 4; k++) begin
      access("R3", 6'h20, 1'b0, 32'h60, 16'(k), 32'h0);
      access("R2", 6'h20, 1'b1, 32'h60, 16'(k), 32'h0);
    end
    // R4 byte stores leave other bytes intact
    for (int k = 0; k < 4; k++) access("R4", 6'h28, k[0], 32'h70, 16'(k), 32'hdeadbe00 | 32'(k));
    access("R5", 6'h23, 1'b0, 32'h70, 16'h0, 32'h0);
    // R1 negative offset and wrap
    access("R1", 6'h23, 1'b0, 32'h100, 16'hfff0, 32'h0);
    access("R1", 6'h20, 1'b0, 32'h0, 16'hfffd, 32'h0);
    // R6 misaligned word accesses
    access("R6", 6'h2b, 1'b0, 32'h80, 16'h1, 32'hcafef00d);
    access("R6", 6'h23, 1'b1, 32'h80, 16'h2, 32'h0);
    access("R6", 6'h23, 1'b0, 32'h80, 16'h0, 32'h0);
    // R7 unknown opcodes
    access("R7", 6'h21, 1'b0, 32'h80, 16'h0, 32'hffffffff);
    access("R7", 6'h3f, 1'b1, 32'h81, 16'h0, 32'hffffffff);
    for (int i = 0; i < 300; i++) begin
      logic [5:0] ops [4] = '{6'h20, 6'h23, 6'h28, 6'h2b};
      access("R2", ops[$urandom_range(0, 3)], 1'($urandom_range(0, 1)),
             32'($urandom_range(64, 191)), 16'(signed'(16'($urandom_range(0, 120)) - 16'd60)),
             $urandom);
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule